// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block is the combinational hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the register numbers read in decode and execute and at the register numbers written by the execute, memory and writeback stages. It also looks at each stage's write-enable, load and branch flags. From these it chooses where each execute-stage ALU operand comes from: the register file, the memory-stage result or the writeback-stage result. It also decides whether each operand of the decode-stage branch comparator takes the memory-stage result.

When a value cannot be forwarded in time, the unit raises a single stall condition. That condition holds the fetch and decode stages and clears the execute stage. There are two causes. One is a load followed at once by an instruction that reads the loaded register. The other is a decode-stage branch that depends on a result still in execute, or on a load still in memory.

The unit has no clock and no state. All its pins are plain control signals: no data stream passes through it, so there is no valid/ready handshake and no back-pressure.

Top module: `hazard_unit`

## Requirements
- R1: `ex_sel_a` is 2'b10 when `rs_ex` is nonzero, equals `dst_mem` and `wen_mem` is high. Failing that, it is 2'b01 when `rs_ex` is nonzero, equals `dst_wb` and `wen_wb` is high. Otherwise it is 2'b00. The memory-stage match wins when both stages match.
- R2: `ex_sel_b` follows the R1 rule and encodings, using `rt_ex` in place of `rs_ex`.
- R3: Register number 0 is never forwarded. When the source register number is 0, the matching select is 2'b00 or the matching comparator forward is 0, whatever the destinations and enables are.
- R4: `id_fwd_a` is 1 exactly when `rs_id` is nonzero, equals `dst_mem` and `wen_mem` is high. `id_fwd_b` follows the same rule using `rt_id`.
- R5: A load-use hazard exists when `load_ex` is high and `rt_ex` equals `rs_id` or `rt_id`.
- R6: A branch hazard exists when `branch_id` and `wen_ex` are high and `dst_ex` equals `rs_id` or `rt_id`.
- R7: A branch hazard also exists when `branch_id` and `load_mem` are high and `dst_mem` equals `rs_id` or `rt_id`.
- R8: `stall_fetch`, `stall_decode` and `flush_exec` are all equal to the OR of the R5, R6 and R7 conditions.
- R9: With every write-enable, load and branch flag low, all outputs are zero.
- R10: Neither execute select ever takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_id | input | AW | First source register read in decode |
| rt_id | input | AW | Second source register read in decode |
| rs_ex | input | AW | First source register of the execute-stage instruction |
| rt_ex | input | AW | Second source register of the execute-stage instruction |
| dst_ex | input | AW | Destination register of the execute-stage instruction |
| dst_mem | input | AW | Destination register of the memory-stage instruction |
| dst_wb | input | AW | Destination register of the writeback-stage instruction |
| wen_ex | input | 1 | Execute-stage instruction writes a register |
| wen_mem | input | 1 | Memory-stage instruction writes a register |
| wen_wb | input | 1 | Writeback-stage instruction writes a register |
| load_ex | input | 1 | Execute-stage instruction loads from memory |
| load_mem | input | 1 | Memory-stage instruction loads from memory |
| branch_id | input | 1 | Decode-stage instruction is a compare-and-branch |
| ex_sel_a | output | 2 | Source select for ALU operand A (00 file, 01 writeback, 10 memory) |
| ex_sel_b | output | 2 | Source select for ALU operand B (same encoding) |
| id_fwd_a | output | 1 | Comparator operand A takes the memory-stage result |
| id_fwd_b | output | 1 | Comparator operand B takes the memory-stage result |
| stall_fetch | output | 1 | Hold the program counter |
| stall_decode | output | 1 | Hold the decode pipeline register |
| flush_exec | output | 1 | Clear the execute pipeline register |

## Verification
Register numbers are drawn at random from a small range, so matches between sources and destinations happen often. Flags are drawn independently, so each cause is seen with every mix of enables. Directed cases then pin down the rest. A case where both the memory and writeback stages match shows the priority order. A case with register 0 matched and enabled everywhere shows that it is never forwarded. Single-cause cases show that a load-use hazard, an execute-stage branch dependency and a memory-stage load branch dependency each raise the stall alone. A case with every flag low and all register numbers equal shows that the unit stays idle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_FILE = 2'b00,
    SRC_WB   = 2'b01,
    SRC_MEM  = 2'b10
  } ex_src_e;
endpackage

// File: rtl/ex_operand_fwd.sv
module ex_operand_fwd #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]       src,
  input  logic [AW-1:0]       dst_mem,
  input  logic                wen_mem,
  input  logic [AW-1:0]       dst_wb,
  input  logic                wen_wb,
  output hazard_pkg::ex_src_e sel
);
  logic nz, hit_mem, hit_wb;
  assign nz      = (src != '0);
  assign hit_mem = nz && wen_mem && (src == dst_mem);
  assign hit_wb  = nz && wen_wb && (src == dst_wb);

  always_comb begin
    if (hit_mem)     sel = hazard_pkg::SRC_MEM;
    else if (hit_wb) sel = hazard_pkg::SRC_WB;
    else             sel = hazard_pkg::SRC_FILE;
  end
endmodule

// File: rtl/id_cmp_fwd.sv
module id_cmp_fwd #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst_mem,
  input  logic          wen_mem,
  output logic          hit
);
  assign hit = (src != '0) && wen_mem && (src == dst_mem);
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_id,
  input  logic [AW-1:0] rt_id,
  input  logic [AW-1:0] rt_ex,
  input  logic [AW-1:0] dst_ex,
  input  logic [AW-1:0] dst_mem,
  input  logic          load_ex,
  input  logic          wen_ex,
  input  logic          load_mem,
  input  logic          branch_id,
  output logic          stall
);
  logic load_use, br_on_ex, br_on_mem;
  assign load_use  = load_ex && ((rt_ex == rs_id) || (rt_ex == rt_id));
  assign br_on_ex  = branch_id && wen_ex && ((dst_ex == rs_id) || (dst_ex == rt_id));
  assign br_on_mem = branch_id && load_mem && ((dst_mem == rs_id) || (dst_mem == rt_id));
  assign stall     = load_use || br_on_ex || br_on_mem;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_id,
  input  logic [AW-1:0] rt_id,
  input  logic [AW-1:0] rs_ex,
  input  logic [AW-1:0] rt_ex,
  input  logic [AW-1:0] dst_ex,
  input  logic [AW-1:0] dst_mem,
  input  logic [AW-1:0] dst_wb,
  input  logic          wen_ex,
  input  logic          wen_mem,
  input  logic          wen_wb,
  input  logic          load_ex,
  input  logic          load_mem,
  input  logic          branch_id,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          stall_fetch,
  output logic          stall_decode,
  output logic          flush_exec
);
  localparam int NOPS = 2;

  logic [AW-1:0]       ex_src [NOPS];
  logic [AW-1:0]       id_src [NOPS];
  hazard_pkg::ex_src_e ex_sel [NOPS];
  logic [NOPS-1:0]     id_hit;
  logic                stall;

  assign ex_src[0] = rs_ex;
  assign ex_src[1] = rt_ex;
  assign id_src[0] = rs_id;
  assign id_src[1] = rt_id;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    ex_operand_fwd #(.AW(AW)) u_ex_fwd (
      .src(ex_src[i]), .dst_mem(dst_mem), .wen_mem(wen_mem),
      .dst_wb(dst_wb), .wen_wb(wen_wb), .sel(ex_sel[i])
    );
    id_cmp_fwd #(.AW(AW)) u_id_fwd (
      .src(id_src[i]), .dst_mem(dst_mem), .wen_mem(wen_mem), .hit(id_hit[i])
    );
  end

  stall_ctrl #(.AW(AW)) u_stall (
    .rs_id(rs_id), .rt_id(rt_id), .rt_ex(rt_ex), .dst_ex(dst_ex),
    .dst_mem(dst_mem), .load_ex(load_ex), .wen_ex(wen_ex),
    .load_mem(load_mem), .branch_id(branch_id), .stall(stall)
  );

  assign ex_sel_a     = ex_sel[0];
  assign ex_sel_b     = ex_sel[1];
  assign id_fwd_a     = id_hit[0];
  assign id_fwd_b     = id_hit[1];
  assign stall_fetch  = stall;
  assign stall_decode = stall;
  assign flush_exec   = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] rs_id,
  input logic [AW-1:0] rt_id,
  input logic [AW-1:0] rs_ex,
  input logic [AW-1:0] rt_ex,
  input logic [AW-1:0] dst_ex,
  input logic [AW-1:0] dst_mem,
  input logic [AW-1:0] dst_wb,
  input logic          wen_ex,
  input logic          wen_mem,
  input logic          wen_wb,
  input logic          load_ex,
  input logic          load_mem,
  input logic          branch_id,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          id_fwd_a,
  input logic          id_fwd_b,
  input logic          stall_fetch,
  input logic          stall_decode,
  input logic          flush_exec
);
  always_comb begin
    assert_no_sel3_R10: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11)
      else $error("execute select took 2'b11");
    assert_zero_reg_R3: assert ((rs_ex != '0 || ex_sel_a == 2'b00) &&
                                (rt_ex != '0 || ex_sel_b == 2'b00) &&
                                (rs_id != '0 || !id_fwd_a) &&
                                (rt_id != '0 || !id_fwd_b))
      else $error("register 0 forwarded");
    assert_mem_sel_R1: assert (ex_sel_a != 2'b10 || (wen_mem && rs_ex == dst_mem))
      else $error("operand A memory select without a memory match");
    assert_wb_sel_R2: assert (ex_sel_b != 2'b01 || (wen_wb && rt_ex == dst_wb))
      else $error("operand B writeback select without a writeback match");
    assert_id_fwd_R4: assert ((!id_fwd_a || (wen_mem && rs_id == dst_mem)) &&
                              (!id_fwd_b || (wen_mem && rt_id == dst_mem)))
      else $error("comparator forward without a memory match");
    assert_stall_cause_R8: assert (!stall_fetch || load_ex || branch_id)
      else $error("stall with neither load nor branch");
    assert_stall_same_R8: assert (stall_fetch == stall_decode && stall_decode == flush_exec)
      else $error("stall outputs disagree");
    assert_idle_R9: assert ((wen_ex || wen_mem || wen_wb || load_ex || load_mem || branch_id) ||
                            (ex_sel_a == 2'b00 && ex_sel_b == 2'b00 && !id_fwd_a &&
                             !id_fwd_b && !stall_fetch))
      else $error("outputs active with all flags low");
  end
endmodule

bind hazard_unit hazard_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] rs_id, rt_id, rs_ex, rt_ex, dst_ex, dst_mem, dst_wb;
  logic wen_ex, wen_mem, wen_wb, load_ex, load_mem, branch_id;
  logic [1:0] ex_sel_a, ex_sel_b;
  logic id_fwd_a, id_fwd_b, stall_fetch, stall_decode, flush_exec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  hazard_unit #(.AW(AW)) u_dut (.*);

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (s != 0 && wen_mem && s == dst_mem) return 2'b10;
    if (s != 0 && wen_wb && s == dst_wb)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic ref_id(logic [AW-1:0] s);
    return (s != 0) && wen_mem && (s == dst_mem);
  endfunction

  function automatic logic ref_stall();
    logic lu, be, bm;
    lu = load_ex && (rt_ex == rs_id || rt_ex == rt_id);
    be = branch_id && wen_ex && (dst_ex == rs_id || dst_ex == rt_id);
    bm = branch_id && load_mem && (dst_mem == rs_id || dst_mem == rt_id);
    return lu || be || bm;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic s;
    #2;
    s = ref_stall();
    chk({"R1 ex_sel_a ", tag}, ex_sel_a, ref_sel(rs_ex));
    chk({"R2 ex_sel_b ", tag}, ex_sel_b, ref_sel(rt_ex));
    chk({"R4 id_fwd_a ", tag}, {1'b0, id_fwd_a}, {1'b0, ref_id(rs_id)});
    chk({"R4 id_fwd_b ", tag}, {1'b0, id_fwd_b}, {1'b0, ref_id(rt_id)});
    chk({"R8 stall_fetch ", tag}, {1'b0, stall_fetch}, {1'b0, s});
    chk({"R8 stall_decode ", tag}, {1'b0, stall_decode}, {1'b0, s});
    chk({"R8 flush_exec ", tag}, {1'b0, flush_exec}, {1'b0, s});
  endtask

  task automatic clear();
    {rs_id, rt_id, rs_ex, rt_ex, dst_ex, dst_mem, dst_wb} = '0;
    {wen_ex, wen_mem, wen_wb, load_ex, load_mem, branch_id} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear();
    repeat (3) @(negedge clk);
    // R9 reset state: all flags low
    check_all("reset R9");
    chk("R9 idle sel", ex_sel_a | ex_sel_b, 2'b00);
    rst_n = 1'b1;

    // R9: flags low, all numbers equal and nonzero
    @(negedge clk); clear();
    {rs_id, rt_id, rs_ex, rt_ex, dst_ex, dst_mem, dst_wb} = {7{5'd3}};
    check_all("idle R9");
    chk("R9 idle stall", {1'b0, stall_fetch}, 2'b00);

    // R1 priority: memory beats writeback
    @(negedge clk); clear();
    rs_ex = 5'd4; rt_ex = 5'd4; dst_mem = 5'd4; dst_wb = 5'd4; wen_mem = 1; wen_wb = 1;
    check_all("priority R1");
    chk("R1 priority mem", ex_sel_a, 2'b10);

    // R2 writeback only
    @(negedge clk); clear();
    rt_ex = 5'd7; dst_wb = 5'd7; wen_wb = 1;
    check_all("wb R2");
    chk("R2 wb select", ex_sel_b, 2'b01);

    // R3 register zero never forwarded
    @(negedge clk); clear();
    wen_mem = 1; wen_wb = 1; wen_ex = 1;
    check_all("zero R3");
    chk("R3 zero reg", {ex_sel_a | ex_sel_b} | {1'b0, id_fwd_a | id_fwd_b}, 2'b00);

    // R4 comparator forward
    @(negedge clk); clear();
    rs_id = 5'd9; rt_id = 5'd10; dst_mem = 5'd10; wen_mem = 1;
    check_all("idfwd R4");
    chk("R4 id_fwd_b set", {id_fwd_a, id_fwd_b}, 2'b01);

    // R5 load-use
    @(negedge clk); clear();
    load_ex = 1; rt_ex = 5'd6; rs_id = 5'd6; rt_id = 5'd1;
    check_all("loaduse R5");
    chk("R5 load-use stall", {1'b0, stall_fetch}, 2'b01);

    // R6 branch on execute result
    @(negedge clk); clear();
    branch_id = 1; wen_ex = 1; dst_ex = 5'd12; rt_id = 5'd12; rs_id = 5'd2; rt_ex = 5'd30;
    check_all("brex R6");
    chk("R6 branch ex stall", {1'b0, flush_exec}, 2'b01);

    // R7 branch on memory-stage load
    @(negedge clk); clear();
    branch_id = 1; load_mem = 1; dst_mem = 5'd13; rs_id = 5'd13; rt_id = 5'd2; rt_ex = 5'd30;
    check_all("brmem R7");
    chk("R7 branch mem stall", {1'b0, stall_decode}, 2'b01);

    // R7 without branch flag: no stall
    @(negedge clk);
    branch_id = 0;
    check_all("nobr R7");
    chk("R7 no branch no stall", {1'b0, stall_decode}, 2'b00);

    // random mix: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rs_id   = 5'($urandom_range(0, 3));
      rt_id   = 5'($urandom_range(0, 3));
      rs_ex   = 5'($urandom_range(0, 3));
      rt_ex   = 5'($urandom_range(0, 3));
      dst_ex  = 5'($urandom_range(0, 3));
      dst_mem = 5'($urandom_range(0, 3));
      dst_wb  = 5'($urandom_range(0, 3));
      {wen_ex, wen_mem, wen_wb, load_ex, load_mem, branch_id} = 6'($urandom);
      check_all("random");
      chk("R10 no 11", {ex_sel_a == 2'b11, ex_sel_b == 2'b11}, 2'b00);
    end

    finish_run();
  end
endmodule